// File: doc/BRIEF.md
# Delay calibration parameter calculator

This block turns five 16-bit calibration readings into two 32-bit per-element delay parameters. The readings are a reference clock period, a coarse reference count, a coarse delay count, a fine reference count and a fine delay count. One parameter is for the coarse delay elements and one is for the fine delay elements. A one-cycle `start` pulse captures the readings into internal registers. A sequencer then works through two ratio calculations, coarse first and fine second. Both calculations share one restoring divider that produces one quotient bit per clock.

At the end the block raises `done` and reports a 2-bit error code. The code flags a zero delay count, which is never used as a divisor, and it flags a quotient that comes out as zero. The results, the code and `done` hold until the next accepted start. A start that arrives while the sequence is running is ignored.

The sequencer has six states:
- `S_IDLE`: after reset.
- `S_C_CHECK`: tests the coarse delay count.
- `S_C_DIV`: the coarse division.
- `S_F_CHECK`: tests the fine delay count.
- `S_F_DIV`: the fine division.
- `S_DONE`: results held.

Its transitions are:
- From `S_IDLE` or `S_DONE`, a start goes to `S_C_CHECK`.
- `S_C_CHECK` goes to `S_DONE` on a zero count, and otherwise launches the divider and goes to `S_C_DIV`.
- `S_C_DIV`, when the divider finishes, goes to `S_DONE` on a zero quotient and otherwise to `S_F_CHECK`.
- `S_F_CHECK` goes to `S_DONE` on a zero count, and otherwise launches the divider and goes to `S_F_DIV`.
- `S_F_DIV`, when the divider finishes, goes to `S_DONE`.

Top module: `dcal_param_calc`

## Requirements
- R1: After reset, `done` and `busy` are 0, `err_code` is 0, and `coarse_param` and `fine_param` are 0.
- R2: With no error, `coarse_param` equals floor(10·P·CR / (176·CD)) truncated to 32 bits. Here P, CR and CD are the period, coarse reference count and coarse delay count captured at start, and 176 is 2·88. `err_code` is then 0.
- R3: With no error, `fine_param` equals floor(10·P·FR / (528·FD)) truncated to 32 bits. Here FR and FD are the fine reference and fine delay counts, and 528 is 2·264.
- R4: If CD is 0, `err_code` becomes 1, both parameters stay 0, and the divider is never loaded with a zero divisor.
- R5: If CD is nonzero, the coarse result is nonzero and FD is 0, then `err_code` is 1, `coarse_param` holds the R2 value and `fine_param` stays 0.
- R6: If the coarse quotient is 0, `err_code` is 2 and both parameters read 0.
- R7: If the coarse result is nonzero and the fine quotient is 0, `err_code` is 2, `coarse_param` holds the R2 value and `fine_param` reads 0.
- R8: The coarse result is produced before the fine one. Any coarse failure ends the sequence with `fine_param` left at 0.
- R9: While `done` is 1 and no start arrives, `done`, `err_code` and both parameters stay unchanged, even when the input ports change.
- R10: A start pulse or input change while `busy` is 1 has no effect, including a start in the cycle where the sequence finishes. The results reflect the values captured at the accepted start.
- R11: A start sampled while not busy makes `busy` 1 and `done` 0 from the next cycle.
- R12: Counting from the clock edge that samples start, `done` rises after the following number of cycles, with W = 2·16+4 = 36:
  - 1 cycle for a zero CD;
  - W+2 = 38 cycles for a zero coarse quotient;
  - W+3 = 39 cycles for a zero FD;
  - 2W+4 = 76 cycles for a run that reaches the fine division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to capture inputs and compute |
| ref_period | input | 16 | Reference clock period reading |
| crs_ref_cnt | input | 16 | Coarse reference count |
| crs_dly_cnt | input | 16 | Coarse delay count |
| fin_ref_cnt | input | 16 | Fine reference count |
| fin_dly_cnt | input | 16 | Fine delay count |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Results valid and held |
| err_code | output | 2 | 0 ok, 1 zero delay count, 2 zero result |
| coarse_param | output | 32 | Coarse per-element delay parameter |
| fine_param | output | 32 | Fine per-element delay parameter |

## Verification
A new start pulse can coincide with the end of the sequence. In the same cycle, the divider finishes the fine quotient and the sequencer moves to `S_DONE`. The bench provokes this by raising start at exactly the edge that completes the run, using the known cycle count from R12. It also restarts and scrambles the inputs a few cycles into the run. It then judges that `done` still rises on schedule with the results of the originally captured values, and that both stay put while the inputs keep changing.

// File: rtl/dcal_pkg.sv
package dcal_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_C_CHECK,
        S_C_DIV,
        S_F_CHECK,
        S_F_DIV,
        S_DONE
    } dcal_state_e;

    typedef enum logic [1:0] {
        ERR_NONE        = 2'd0,
        ERR_ZERO_COUNT  = 2'd1,
        ERR_ZERO_RESULT = 2'd2
    } dcal_err_e;

    localparam int PHASE_COUNT = 2;

endpackage

// File: rtl/dcal_operands.sv
module dcal_operands #(
    parameter int IN_W  = 16,
    parameter int MULT  = 88,
    parameter int NUM_W = 36,
    parameter int DEN_W = 26
) (
    input  logic [IN_W-1:0]  period,
    input  logic [IN_W-1:0]  ref_cnt,
    input  logic [IN_W-1:0]  dly_cnt,
    output logic [NUM_W-1:0] num,
    output logic [DEN_W-1:0] den
);

    // Dividend: ten times period times reference count.
    assign num = NUM_W'(10) * NUM_W'(period) * NUM_W'(ref_cnt);
    // Divisor: twice the hard multiplier times the delay count.
    assign den = DEN_W'(2 * MULT) * DEN_W'(dly_cnt);

endmodule

// File: rtl/dcal_divider.sv
module dcal_divider #(
    parameter int NUM_W = 36,
    parameter int DEN_W = 26,
    parameter int Q_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [Q_W-1:0]   quo,
    output logic             fin
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_r;
    logic [DEN_W-1:0] rem_r;
    logic [DEN_W-1:0] den_r;
    logic [CNT_W-1:0] cnt_r;
    logic             run_r;
    logic [DEN_W:0]   trial;
    logic             ge;

    assign trial = {rem_r, quo_r[NUM_W-1]};
    assign ge    = (trial >= {1'b0, den_r});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_r <= '0;
            rem_r <= '0;
            den_r <= '0;
            cnt_r <= '0;
            run_r <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                quo_r <= num;
                rem_r <= '0;
                den_r <= den;
                cnt_r <= CNT_W'(NUM_W);
                run_r <= 1'b1;
            end else if (run_r) begin
                quo_r <= {quo_r[NUM_W-2:0], ge};
                rem_r <= ge ? DEN_W'(trial - {1'b0, den_r}) : DEN_W'(trial);
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CNT_W'(1)) begin
                    run_r <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    // Quotient truncated to the result width.
    assign quo = quo_r[Q_W-1:0];

    // R4: a zero divisor is never loaded
    a_r4_no_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (den != '0));

    // R2: partial remainder stays below the divisor while iterating
    a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_r |-> (rem_r < den_r));

    // R12: a finish pulse lasts one cycle
    a_r12_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

endmodule

// File: rtl/dcal_param_calc.sv
module dcal_param_calc
    import dcal_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int Q_W    = 32,
    parameter int C_MULT = 88,
    parameter int F_MULT = 264
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [IN_W-1:0] ref_period,
    input  logic [IN_W-1:0] crs_ref_cnt,
    input  logic [IN_W-1:0] crs_dly_cnt,
    input  logic [IN_W-1:0] fin_ref_cnt,
    input  logic [IN_W-1:0] fin_dly_cnt,
    output logic            busy,
    output logic            done,
    output logic [1:0]      err_code,
    output logic [Q_W-1:0]  coarse_param,
    output logic [Q_W-1:0]  fine_param
);

    localparam int NUM_W    = 2 * IN_W + 4;
    localparam int MULT_MAX = (C_MULT > F_MULT) ? C_MULT : F_MULT;
    localparam int DEN_W    = IN_W + $clog2(2 * MULT_MAX + 1);

    dcal_state_e     state_q, state_d;
    dcal_err_e       err_q;
    logic [IN_W-1:0] per_q;
    logic [IN_W-1:0] ref_q [PHASE_COUNT];
    logic [IN_W-1:0] dly_q [PHASE_COUNT];
    logic [Q_W-1:0]  coarse_q, fine_q;

    logic [NUM_W-1:0] num_a [PHASE_COUNT];
    logic [DEN_W-1:0] den_a [PHASE_COUNT];
    logic [NUM_W-1:0] num_sel;
    logic [DEN_W-1:0] den_sel;
    logic             phase_fine;
    logic             launch;
    logic             accept;
    logic             div_fin;
    logic [Q_W-1:0]   div_quo;

    // One operand builder per phase, each with its own hard multiplier.
    for (genvar g = 0; g < PHASE_COUNT; g++) begin : g_phase
        localparam int MULT = (g == 0) ? C_MULT : F_MULT;
        dcal_operands #(
            .IN_W (IN_W),
            .MULT (MULT),
            .NUM_W(NUM_W),
            .DEN_W(DEN_W)
        ) u_ops (
            .period (per_q),
            .ref_cnt(ref_q[g]),
            .dly_cnt(dly_q[g]),
            .num    (num_a[g]),
            .den    (den_a[g])
        );
    end

    assign phase_fine = (state_q == S_F_CHECK) || (state_q == S_F_DIV);
    assign num_sel    = phase_fine ? num_a[1] : num_a[0];
    assign den_sel    = phase_fine ? den_a[1] : den_a[0];

    dcal_divider #(
        .NUM_W(NUM_W),
        .DEN_W(DEN_W),
        .Q_W  (Q_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .load (launch),
        .num  (num_sel),
        .den  (den_sel),
        .quo  (div_quo),
        .fin  (div_fin)
    );

    assign accept = start && ((state_q == S_IDLE) || (state_q == S_DONE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and divider launch
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            S_IDLE, S_DONE: begin
                if (start) state_d = S_C_CHECK;
            end
            S_C_CHECK: begin
                if (dly_q[0] == '0) begin
                    state_d = S_DONE;
                end else begin
                    launch  = 1'b1;
                    state_d = S_C_DIV;
                end
            end
            S_C_DIV: begin
                if (div_fin) state_d = (div_quo == '0) ? S_DONE : S_F_CHECK;
            end
            S_F_CHECK: begin
                if (dly_q[1] == '0) begin
                    state_d = S_DONE;
                end else begin
                    launch  = 1'b1;
                    state_d = S_F_DIV;
                end
            end
            S_F_DIV: begin
                if (div_fin) state_d = S_DONE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Captured inputs, results and error code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q    <= '0;
            ref_q[0] <= '0;
            ref_q[1] <= '0;
            dly_q[0] <= '0;
            dly_q[1] <= '0;
            coarse_q <= '0;
            fine_q   <= '0;
            err_q    <= ERR_NONE;
        end else if (accept) begin
            per_q    <= ref_period;
            ref_q[0] <= crs_ref_cnt;
            ref_q[1] <= fin_ref_cnt;
            dly_q[0] <= crs_dly_cnt;
            dly_q[1] <= fin_dly_cnt;
            coarse_q <= '0;
            fine_q   <= '0;
            err_q    <= ERR_NONE;
        end else begin
            unique case (state_q)
                S_C_CHECK: if (dly_q[0] == '0) err_q <= ERR_ZERO_COUNT;
                S_F_CHECK: if (dly_q[1] == '0) err_q <= ERR_ZERO_COUNT;
                S_C_DIV: if (div_fin) begin
                    coarse_q <= div_quo;
                    if (div_quo == '0) err_q <= ERR_ZERO_RESULT;
                end
                S_F_DIV: if (div_fin) begin
                    fine_q <= div_quo;
                    if (div_quo == '0) err_q <= ERR_ZERO_RESULT;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy = (state_q != S_IDLE) && (state_q != S_DONE);
        done = (state_q == S_DONE);
    end

    assign err_code     = err_q;
    assign coarse_param = coarse_q;
    assign fine_param   = fine_q;

    // R11: an accepted start leaves busy set and done clear
    a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R9: held results do not move without a start
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(coarse_param) && $stable(fine_param)
                              && $stable(err_code)));

    // R10: captured inputs never change while busy
    a_r10_busy_latch: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(per_q) && $stable(dly_q[0]) && $stable(dly_q[1])
                  && $stable(ref_q[0]) && $stable(ref_q[1])));

    // R8: fine phase is reached only after a good coarse result
    a_r8_coarse_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_F_CHECK) |-> ((coarse_q != '0) && (err_q == ERR_NONE)));

    // R4: zero coarse count leaves both results at zero
    a_r4_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (dly_q[0] == '0)) |-> ((coarse_q == '0) && (fine_q == '0)
                                        && (err_q == ERR_ZERO_COUNT)));

endmodule

// File: tb/dcal_param_calc_test.sv
`timescale 1ns/1ps
module dcal_param_calc_test;

    localparam int IN_W = 16;
    localparam int W    = 2 * IN_W + 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] ref_period = '0, crs_ref_cnt = '0, crs_dly_cnt = '0;
    logic [15:0] fin_ref_cnt = '0, fin_dly_cnt = '0;
    logic        busy, done;
    logic [1:0]  err_code;
    logic [31:0] coarse_param, fine_param;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dcal_param_calc uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ref_period(ref_period), .crs_ref_cnt(crs_ref_cnt), .crs_dly_cnt(crs_dly_cnt),
        .fin_ref_cnt(fin_ref_cnt), .fin_dly_cnt(fin_dly_cnt),
        .busy(busy), .done(done), .err_code(err_code),
        .coarse_param(coarse_param), .fine_param(fine_param)
    );

    function automatic logic [31:0] ratio(input logic [15:0] p, r, d, input int unsigned m);
        longint unsigned n, q;
        n = 64'd10 * 64'(p) * 64'(r);
        q = n / (64'd2 * 64'(d) * 64'(m));
        return q[31:0];
    endfunction

    task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // inject: restart and scramble mid-run, and restart at the finishing edge
    task automatic run_case(input logic [15:0] p, cr, cd, fr, fd, input bit inject);
        logic [31:0] ec, ef;
        int ee, lat, k;
        string te;
        ec = '0; ef = '0; ee = 0; te = "R2";
        if (cd == 0) begin
            ee = 1; lat = 1; te = "R4";
        end else begin
            ec = ratio(p, cr, cd, 88);
            if (ec == 0) begin
                ee = 2; lat = W + 2; te = "R6";
            end else if (fd == 0) begin
                ee = 1; lat = W + 3; te = "R5";
            end else begin
                ef = ratio(p, fr, fd, 264);
                lat = 2 * W + 4;
                if (ef == 0) begin ee = 2; te = "R7"; end
            end
        end
        ref_period = p; crs_ref_cnt = cr; crs_dly_cnt = cd;
        fin_ref_cnt = fr; fin_dly_cnt = fd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 busy after start", busy, 1);
        check("R11 done cleared", done, 0);
        k = 0;
        while (!done && k < 400) begin
            @(negedge clk);
            k++;
            if (inject && k == 3) begin
                start = 1'b1;
                ref_period = ~p; crs_dly_cnt = cd ^ 16'h5a5a; fin_dly_cnt = 16'h0;
            end
            if (inject && k == 4) start = 1'b0;
            if (inject && lat > 2 && k == lat - 1) start = 1'b1;
        end
        start = 1'b0;
        check("R12 latency", k, lat);
        check("R10/R2 coarse", coarse_param, ec);
        check("R3 fine", fine_param, ef);
        check({te, " err"}, err_code, ee);
        if (ee != 0 && ef == 0) check("R8 fine untouched", fine_param, 0);
        if (inject) begin
            ref_period = 16'h1234; crs_dly_cnt = 16'h0; fin_ref_cnt = 16'hffff;
            repeat (10) @(negedge clk);
            check("R9 done held", done, 1);
            check("R9 coarse held", coarse_param, ec);
            check("R9 fine held", fine_param, ef);
            check("R9 err held", err_code, ee);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] p, cr, cd, fr, fd;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 done", done, 0);
        check("R1 busy", busy, 0);
        check("R1 err", err_code, 0);
        check("R1 coarse", coarse_param, 0);
        check("R1 fine", fine_param, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corner cases
        run_case(16'd1000, 16'd500, 16'd20, 16'd700, 16'd15, 1'b0);   // R2 R3 normal
        run_case(16'd1000, 16'd500, 16'd0, 16'd700, 16'd15, 1'b0);    // R4 zero coarse count
        run_case(16'd1000, 16'd500, 16'd20, 16'd700, 16'd0, 1'b0);    // R5 zero fine count
        run_case(16'd1, 16'd1, 16'd1, 16'd700, 16'd15, 1'b0);         // R6 zero coarse result
        run_case(16'd1000, 16'd500, 16'd20, 16'd0, 16'd15, 1'b0);     // R7 zero fine result
        run_case(16'hffff, 16'hffff, 16'd1, 16'hffff, 16'd1, 1'b0);   // R2 R3 largest
        run_case(16'hffff, 16'hffff, 16'hffff, 16'hffff, 16'hffff, 1'b0);
        run_case(16'd3000, 16'd4000, 16'd77, 16'd900, 16'd33, 1'b1);  // R10 R9 collisions
        run_case(16'd1000, 16'd500, 16'd0, 16'd700, 16'd15, 1'b1);    // R4 with restarts
        // constrained random
        for (int i = 0; i < 40; i++) begin
            p  = 16'($urandom);
            cr = 16'($urandom);
            fr = ($urandom % 10 == 0) ? 16'd0 : 16'($urandom);
            cd = ($urandom % 8 == 0) ? 16'd0 : 16'($urandom);
            fd = ($urandom % 8 == 0) ? 16'd0 : 16'($urandom % 4096);
            run_case(p, cr, cd, fr, fd, (i % 5 == 0));
        end
        finish_run();
    end

endmodule